// File: doc/BRIEF.md
# Asynchronous Peripheral Bus Master Sequencer

This block turns a one-cycle internal request into a fixed eight-phase cycle on an asynchronous peripheral bus. The request carries an address, write data and a direction flag. The block drives an address strobe, a data strobe and a read/write line, all active low except read/write, which is high for a read. It enables the data bus output drivers only for writes. Before it completes a cycle it waits for a data-transfer acknowledge from the peripheral.

The phases are numbered S0 to S7, and each one lasts one system clock. The acknowledge input passes through a two-flop synchronizer. The block samples it at the end of S3. If it is not present then, the block inserts one-clock wait phases after S4 until it arrives. On reads, the bus data is latched on the clock edge that ends S6. That data is then presented together with a one-cycle completion pulse.

Top module: `pbus_master`

The cycle numbering below counts clock edges. Edge E0 is the first edge at which `req_start` is sampled high while the block is idle. W is the number of wait phases inserted.

## Requirements
- R1: After reset, and whenever reset is applied in the middle of a cycle, the block is idle with `bus_as_n`=1, `bus_ds_n`=1, `bus_rw`=1, `bus_doe`=0, `busy`=0 and `done`=0.
- R2: `busy` rises after E0. `bus_addr` shows the requested address from E1 (entry to S1) onward and holds it until the next accepted request.
- R3: `bus_as_n` is 0 from E2 through E6+W and returns to 1 at E7+W (entry to S7).
- R4: For a write, `bus_rw` is 0 from E2 through E7+W and returns to 1 at E8+W (end of S7). For a read it stays 1 throughout, and it is always 1 in S0 and S1.
- R5: For a write, `bus_doe` is 1 and `bus_dout` carries the write data from E3 through E7+W. `bus_doe` never rises on a read and never rises while `bus_rw` is 1.
- R6: `bus_ds_n` is 0 from E4 through E6+W and is never low while `bus_as_n` is high.
- R7: Let `bus_dtack_n` first be sampled low at edge Ek and stay low. If k ≤ 2, then W = 0. Otherwise W = max(1, k−3), with each wait phase lasting exactly one clock.
- R8: For a read, the value on `bus_din` at edge E7+W is presented on `rd_data` when `done` is high.
- R9: `busy` stays 1 through S7. At E8+W, `busy` falls and `done` is 1 for exactly one cycle.
- R10: A `req_start` that arrives while a cycle is in progress is ignored. It does not change the address and does not start another cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Request strobe, accepted only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | A bus cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Latched read data |
| bus_addr | output | ADDR_W | External address bus |
| bus_dout | output | DATA_W | External data bus, output side |
| bus_doe | output | 1 | Data bus output enable |
| bus_din | input | DATA_W | External data bus, input side |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_dtack_n | input | 1 | Transfer acknowledge, active low, asynchronous |

## Verification
Every output of the block is a register loaded from the next phase, so each output is due a fixed number of edges after E0:
- the address one edge after E0;
- the address strobe and read/write two edges after;
- the drivers three edges after;
- the data strobe four edges after;
- release of the strobes at 7+W and completion at 8+W.

The bench chooses the edge at which it lowers the acknowledge, derives W from R7, and then compares every output at the falling clock edge after each rising edge against these windows. Read data is placed on the bus only in the S6 cycle, so a capture one edge early or late is caught. A second start is poked mid-cycle, and the bench then checks that the bus stays idle afterwards.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_S0   = 4'd1,
    ST_S1   = 4'd2,
    ST_S2   = 4'd3,
    ST_S3   = 4'd4,
    ST_S4   = 4'd5,
    ST_S5   = 4'd6,
    ST_S6   = 4'd7,
    ST_S7   = 4'd8,
    ST_WAIT = 4'd9
  } pbus_st_e;

  // address strobe active in these phases
  function automatic logic ph_as(input pbus_st_e s);
    return s inside {ST_S2, ST_S3, ST_S4, ST_WAIT, ST_S5, ST_S6};
  endfunction

  // data strobe active in these phases
  function automatic logic ph_ds(input pbus_st_e s);
    return s inside {ST_S4, ST_WAIT, ST_S5, ST_S6};
  endfunction

  // write direction held low in these phases
  function automatic logic ph_rw_low(input pbus_st_e s);
    return s inside {ST_S2, ST_S3, ST_S4, ST_WAIT, ST_S5, ST_S6, ST_S7};
  endfunction

  // output drivers enabled (writes) in these phases
  function automatic logic ph_drive(input pbus_st_e s);
    return s inside {ST_S3, ST_S4, ST_WAIT, ST_S5, ST_S6, ST_S7};
  endfunction

endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_start,
  input  logic req_write,
  input  logic dtack_s,
  output logic ld_cmd,
  output logic ld_addr,
  output logic ld_data,
  output logic cap_rd,
  output logic busy,
  output logic done,
  output logic as_n,
  output logic ds_n,
  output logic rw,
  output logic doe
);

  pbus_st_e st_q, st_d;
  logic     wr_q, wr_d;
  logic     ack_ok_q;
  logic     accept;

  assign accept = (st_q == ST_IDLE) && req_start;
  assign wr_d   = accept ? req_write : wr_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: st_d = req_start ? ST_S0 : ST_IDLE;
      ST_S0:   st_d = ST_S1;
      ST_S1:   st_d = ST_S2;
      ST_S2:   st_d = ST_S3;
      ST_S3:   st_d = ST_S4;
      ST_S4:   st_d = ack_ok_q ? ST_S5 : ST_WAIT;
      ST_WAIT: st_d = dtack_s ? ST_S5 : ST_WAIT;
      ST_S5:   st_d = ST_S6;
      ST_S6:   st_d = ST_S7;
      ST_S7:   st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // datapath load strobes, each one edge ahead of the phase it serves
  assign ld_cmd  = accept;
  assign ld_addr = (st_q == ST_S0);
  assign ld_data = (st_q == ST_S2);
  assign cap_rd  = (st_q == ST_S6) && !wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      wr_q     <= 1'b0;
      ack_ok_q <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      as_n     <= 1'b1;
      ds_n     <= 1'b1;
      rw       <= 1'b1;
      doe      <= 1'b0;
    end else begin
      st_q <= st_d;
      wr_q <= wr_d;
      if (st_q == ST_S3) ack_ok_q <= dtack_s;
      busy <= (st_d != ST_IDLE);
      done <= (st_q == ST_S7);
      as_n <= !ph_as(st_d);
      ds_n <= !ph_ds(st_d);
      rw   <= !(wr_d && ph_rw_low(st_d));
      doe  <= wr_d && ph_drive(st_d);
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (as_n && ds_n && rw && !doe && !busy && !done));

  assert_rw_released_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> rw);

  assert_drive_only_write_R5: assert property (@(posedge clk) disable iff (rst)
    doe |-> !rw);

  assert_ds_inside_as_R6: assert property (@(posedge clk) disable iff (rst)
    !ds_n |-> !as_n);

  assert_wait_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT && !dtack_s) |=> (st_q == ST_WAIT));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_no_restart_R10: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE && req_start) |=> (st_q != ST_S0));

endmodule

// File: rtl/pbus_dp.sv
module pbus_dp #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_cmd,
  input  logic              ld_addr,
  input  logic              ld_data,
  input  logic              cap_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic [DATA_W-1:0] rd_data
);

  logic [ADDR_W-1:0] addr_h;
  logic [DATA_W-1:0] wdata_h;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_h   <= '0;
      wdata_h  <= '0;
      bus_addr <= '0;
      bus_dout <= '0;
      rd_data  <= '0;
    end else begin
      if (ld_cmd) begin
        addr_h  <= req_addr;
        wdata_h <= req_wdata;
      end
      if (ld_addr) bus_addr <= addr_h;
      if (ld_data) bus_dout <= wdata_h;
      if (cap_rd)  rd_data  <= bus_din;
    end
  end

endmodule

// File: rtl/pbus_master.sv
module pbus_master #(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_start,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  output logic              bus_as_n,
  output logic              bus_ds_n,
  output logic              bus_rw,
  input  logic              bus_dtack_n
);

  logic dtack_n_s, dtack_s;
  logic ld_cmd, ld_addr, ld_data, cap_rd;

  pbus_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (bus_dtack_n),
    .q   (dtack_n_s)
  );

  assign dtack_s = !dtack_n_s;

  pbus_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_start (req_start),
    .req_write (req_write),
    .dtack_s   (dtack_s),
    .ld_cmd    (ld_cmd),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data),
    .cap_rd    (cap_rd),
    .busy      (busy),
    .done      (done),
    .as_n      (bus_as_n),
    .ds_n      (bus_ds_n),
    .rw        (bus_rw),
    .doe       (bus_doe)
  );

  pbus_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ld_cmd    (ld_cmd),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data),
    .cap_rd    (cap_rd),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .bus_din   (bus_din),
    .bus_addr  (bus_addr),
    .bus_dout  (bus_dout),
    .rd_data   (rd_data)
  );

  // write data must not move while the drivers are on
  assert_dout_steady_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_doe && $past(bus_doe)) |-> $stable(bus_dout));

  // address must not move while the strobe is asserted
  assert_addr_steady_R2: assert property (@(posedge clk) disable iff (rst)
    (!bus_as_n && $past(!bus_as_n)) |-> $stable(bus_addr));

endmodule

// File: tb/pbus_master_tb.sv
`timescale 1ns/1ps
module pbus_master_tb;

  localparam int AW = 24;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_start = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          busy, done, bus_doe, bus_as_n, bus_ds_n, bus_rw;
  logic [DW-1:0] rd_data, bus_dout;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_din = 8'hA5;
  logic          bus_dtack_n = 1'b1;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pbus_master #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .req_start   (req_start),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .busy        (busy),
    .done        (done),
    .rd_data     (rd_data),
    .bus_addr    (bus_addr),
    .bus_dout    (bus_dout),
    .bus_doe     (bus_doe),
    .bus_din     (bus_din),
    .bus_as_n    (bus_as_n),
    .bus_ds_n    (bus_ds_n),
    .bus_rw      (bus_rw),
    .bus_dtack_n (bus_dtack_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk(bus_as_n == 1'b1, req, "idle as_n", 32'(bus_as_n), 32'd1);
    chk(bus_ds_n == 1'b1, req, "idle ds_n", 32'(bus_ds_n), 32'd1);
    chk(bus_rw == 1'b1,   req, "idle rw",   32'(bus_rw),   32'd1);
    chk(bus_doe == 1'b0,  req, "idle doe",  32'(bus_doe),  32'd0);
    chk(busy == 1'b0,     req, "idle busy", 32'(busy),     32'd0);
    chk(done == 1'b0,     req, "idle done", 32'(done),     32'd0);
  endtask

  // j < 0: acknowledge held low before the request; otherwise driven low
  // on the falling edge after edge Ej (first sampled at E(j+1)).
  task automatic run_cycle(input bit wr, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd, input logic [DW-1:0] rd,
                           input int j, input bit poke);
    int w;
    bit exp_b;
    w = (j <= 1) ? 0 : (((j - 2) > 1) ? (j - 2) : 1);
    @(negedge clk);
    req_start = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    bus_din = 8'hA5;
    if (j < 0) bus_dtack_n = 1'b0;
    for (int e = 0; e <= 9 + w; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (e == 0) begin
        req_start = 1'b0; req_addr = '0; req_wdata = '0;
      end
      exp_b = (e <= 7 + w);
      chk(busy == exp_b, "R9", "busy", 32'(busy), 32'(exp_b));
      exp_b = !(e >= 2 && e <= 6 + w);
      chk(bus_as_n == exp_b, "R3", "as_n", 32'(bus_as_n), 32'(exp_b));
      exp_b = !(e >= 4 && e <= 6 + w);
      chk(bus_ds_n == exp_b, "R6", "ds_n", 32'(bus_ds_n), 32'(exp_b));
      exp_b = !(wr && e >= 2 && e <= 7 + w);
      chk(bus_rw == exp_b, "R4", "rw", 32'(bus_rw), 32'(exp_b));
      exp_b = wr && e >= 3 && e <= 7 + w;
      chk(bus_doe == exp_b, "R5", "doe", 32'(bus_doe), 32'(exp_b));
      exp_b = (e == 8 + w);
      chk(done == exp_b, "R9", "done", 32'(done), 32'(exp_b));
      if (e >= 1)
        chk(bus_addr == a, "R2", "bus_addr", 32'(bus_addr), 32'(a));
      if (wr && e >= 3 && e <= 7 + w)
        chk(bus_dout == wd, "R5", "bus_dout", 32'(bus_dout), 32'(wd));
      if (e == 6 + w)
        chk(bus_ds_n == 1'b0, "R7", "ds held through waits", 32'(bus_ds_n), 32'd0);
      if (e == 7 + w)
        chk(bus_ds_n == 1'b1, "R7", "ds released after waits", 32'(bus_ds_n), 32'd1);
      if (!wr && e == 8 + w)
        chk(rd_data == rd, "R8", "rd_data", 32'(rd_data), 32'(rd));
      if (poke && e == 9 + w) begin
        chk(busy == 1'b0, "R10", "no second cycle", 32'(busy), 32'd0);
        chk(bus_addr == a, "R10", "address kept", 32'(bus_addr), 32'(a));
      end
      // stimulus for the next edge
      if (e == j) bus_dtack_n = 1'b0;
      if (poke && e == 2) begin
        req_start = 1'b1; req_write = !wr; req_addr = ~a;
      end
      if (poke && e == 3) req_start = 1'b0;
      if (e == 6 + w) bus_din = rd;
      if (e == 7 + w) begin
        bus_din = 8'h5A;
        bus_dtack_n = 1'b1;
      end
    end
    if (poke) begin
      repeat (3) begin
        @(posedge clk);
        @(negedge clk);
        chk(bus_as_n == 1'b1 && busy == 1'b0, "R10", "bus stays idle",
            32'({bus_as_n, busy}), 32'b10);
      end
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1");
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    req_start = 1'b1; req_write = 1'b1; req_addr = 24'h00ABCD; req_wdata = 8'h77;
    @(negedge clk);
    req_start = 1'b0;
    repeat (4) @(negedge clk);
    chk(bus_ds_n == 1'b0, "R6", "mid-cycle ds before reset", 32'(bus_ds_n), 32'd0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check_idle("R1");
    repeat (2) @(negedge clk);
    check_idle("R1");
  endtask

  initial begin
    t_reset();
    run_cycle(1'b1, 24'h123456, 8'h3C, 8'h00, -1, 1'b0); // write, no waits
    run_cycle(1'b0, 24'h0F0F0F, 8'h00, 8'hC3,  1, 1'b0); // read, ack at E2 -> W=0
    run_cycle(1'b1, 24'hFFFFFE, 8'h81, 8'h00,  2, 1'b0); // write, one wait (R7)
    run_cycle(1'b0, 24'h000001, 8'h00, 8'h96,  6, 1'b0); // read, four waits (R7)
    run_cycle(1'b1, 24'h2468AC, 8'hE1, 8'h00,  3, 1'b1); // write + ignored start (R10)
    run_cycle(1'b1, 24'h135790, 8'h0F, 8'h00, -1, 1'b0); // back-to-back write (R4)
    run_cycle(1'b0, 24'h135791, 8'h00, 8'h4B, -1, 1'b1); // read + ignored start
    t_reset_mid();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule